// File: doc/BRIEF.md
# First-Fault Predicated Vector Load Sequencer

This block walks the elements of one vector register and loads an unsigned 32-bit word from memory into every element that its governing predicate enables. Reads are contiguous. The start address is a 64-bit base plus a 64-bit index scaled by four. Each element slot moves the address on by four bytes, whether or not that slot is read. Elements are 32 or 64 bits wide, chosen per operation. Every loaded word is zero-extended to the element width.

Only the first active element may raise a real fault. If its read comes back faulted, the operation stops and reports a synchronous fault, and the destination and the first-fault mask keep their values. A fault on any later active element never raises an exception. Instead it sets a sticky condition. That condition clears the first-fault mask from that element to the end of the vector, and no further reads are made. From the first element whose mask bit is low onward, the result is forced to zero. This gives software a deterministic view of how many elements are trustworthy.

The block accepts a one-cycle start pulse and reads all operands at that edge. It talks to memory over a simple hold-until-acknowledge read port that returns a fault flag with the data. It signals completion with a one-cycle done pulse.

Top module: `ffload_seq`

## Requirements
- R1: The read for element slot e uses address base + 4*index + 4*e (modulo 2^64), in both element widths.
- R2: An element whose active bit is 0 causes no memory read and is written as zero in the result.
- R3: The predicate has one bit per vector byte. An element is active when predicate bit 4e is set (32-bit mode, esize64=0) or bit 8e is set (64-bit mode, esize64=1). Other predicate bits have no effect.
- R4: A loaded word fills bits [31:0] of its element. In 64-bit mode, bits [63:32] of the element are zero.
- R5: If the read of the first active element returns mem_fault=1, done comes with sync_fault=1, the result equals prior_vec and ffr_out equals ffr_in.
- R6: If a later active element's read returns mem_fault=1, sync_fault stays 0. The ffr_out bits of that element's byte group and of every later group are cleared, and no further reads are issued.
- R7: From the first element whose ffr_out group-low bit is 0 (including bits already 0 in ffr_in), that element and every later element are zero in the result.
- R8: The first-fault mask bits are only ever cleared, never set. Without a fault, ffr_out equals ffr_in.
- R9: A predicate with no active element completes with no memory read, an all-zero result and ffr_out equal to ffr_in.
- R10: done is a single-cycle pulse. After reset, done, mem_req and sync_fault are 0. A start pulse while an operation is running is ignored.
- R11: mem_req, once raised, stays high with a stable mem_addr until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse; operands sampled here |
| esize64 | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| base_addr | input | 64 | Base byte address |
| index | input | 64 | Element index, scaled by 4 |
| pred | input | VLEN_P/8 | Governing predicate, one bit per vector byte |
| ffr_in | input | VLEN_P/8 | Incoming first-fault mask |
| prior_vec | input | VLEN_P | Prior destination contents |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 64 | Read byte address |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data word |
| mem_fault | input | 1 | Read could not be performed |
| done | output | 1 | One-cycle completion pulse |
| sync_fault | output | 1 | First active element faulted; valid with done |
| result | output | VLEN_P | Loaded vector |
| ffr_out | output | VLEN_P/8 | Updated first-fault mask |

## Verification
Two functions can land on the same acknowledge cycle: abort handling for the first active element, and sticky-fault handling for later elements. Which one applies depends only on whether any active element came before. The bench provokes both by placing the faulting address on slot 0, on a slot whose earlier slots are all inactive, and on slots after a successful read. It then judges result, ffr_out, sync_fault and the number of reads against a model computed element by element. A further case clears an ffr_in group with no fault, so that the zeroing rule acts with no fault path at all.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
   localparam int WORD_W = 32;
   localparam int WORD_BYTES = WORD_W / 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_REQ  = 2'd2,
      ST_FIN  = 2'd3
   } ffl_state_e;
endpackage

// File: rtl/ffl_pred_map.sv
module ffl_pred_map #(
   parameter int VLEN_P = 256
) (
   input  logic [VLEN_P/8-1:0]  pred,
   input  logic                 esize64,
   output logic [VLEN_P/32-1:0] act
);
   localparam int PLEN  = VLEN_P / 8;
   localparam int NWORD = VLEN_P / 32;
   localparam int NE64  = VLEN_P / 64;

   logic [NWORD-1:0] act32;
   logic [NWORD-1:0] act64;
   logic             unused_pred;

   assign unused_pred = ^pred;

   for (genvar e = 0; e < NWORD; e++) begin : g_elem
      assign act32[e] = pred[e*4];
      if (e < NE64) begin : g_wide
         assign act64[e] = pred[e*8];
      end else begin : g_none
         assign act64[e] = 1'b0;
      end
   end

   assign act = esize64 ? act64 : act32;

   if (PLEN != NWORD * 4) begin : g_bad_plen
      $error("ffl_pred_map: predicate width mismatch");
   end
endmodule

// File: rtl/ffl_addr_gen.sv
module ffl_addr_gen #(
   parameter int AW_P = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW_P-1:0] base_addr,
   input  logic [AW_P-1:0] index,
   input  logic            step,
   output logic [AW_P-1:0] addr
);
   import ffl_pkg::*;
   localparam int SHIFT = $clog2(WORD_BYTES);

   logic [AW_P-1:0] addr_q;
   logic [AW_P-1:0] scaled;
   logic            unused_idx;

   assign scaled     = {index[AW_P-SHIFT-1:0], {SHIFT{1'b0}}};
   assign unused_idx = ^index[AW_P-1:AW_P-SHIFT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= base_addr + scaled;
      end else if (step) begin
         addr_q <= addr_q + AW_P'(WORD_BYTES);
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/ffl_ctrl.sv
module ffl_ctrl #(
   parameter int VLEN_P = 256
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          esize64,
   input  logic [VLEN_P/32-1:0]          act_vec,
   input  logic                          mem_ack,
   input  logic                          mem_fault,
   output logic                          load,
   output logic                          mem_req,
   output logic                          step,
   output logic [$clog2(VLEN_P/32)-1:0]  step_idx,
   output logic                          step_clr,
   output logic                          data_valid,
   output logic                          abort,
   output logic                          done
);
   import ffl_pkg::*;
   localparam int NWORD  = VLEN_P / 32;
   localparam int NE64   = VLEN_P / 64;
   localparam int EIDX_W = $clog2(NWORD);
   localparam logic [EIDX_W-1:0] LAST32 = EIDX_W'(NWORD - 1);
   localparam logic [EIDX_W-1:0] LAST64 = EIDX_W'(NE64 - 1);

   ffl_state_e        state_q;
   logic [EIDX_W-1:0] idx_q;
   logic              first_q;
   logic              sticky_q;
   logic              abort_q;
   logic              last;
   logic              want_read;
   logic              hard_fault;
   logic              take;

   assign last       = (idx_q == (esize64 ? LAST64 : LAST32));
   assign want_read  = act_vec[idx_q] && !sticky_q;
   assign hard_fault = first_q && mem_fault;
   assign take       = (state_q == ST_REQ) && mem_ack && !hard_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         first_q  <= 1'b1;
         sticky_q <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q  <= ST_SCAN;
                  idx_q    <= '0;
                  first_q  <= 1'b1;
                  sticky_q <= 1'b0;
                  abort_q  <= 1'b0;
               end
            end
            ST_SCAN: begin
               if (want_read) begin
                  state_q <= ST_REQ;
               end else if (last) begin
                  state_q <= ST_FIN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_REQ: begin
               if (mem_ack) begin
                  if (hard_fault) begin
                     abort_q <= 1'b1;
                     state_q <= ST_FIN;
                  end else begin
                     first_q <= 1'b0;
                     if (mem_fault) begin
                        sticky_q <= 1'b1;
                     end
                     if (last) begin
                        state_q <= ST_FIN;
                     end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_SCAN;
                     end
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign load       = (state_q == ST_IDLE) && start;
   assign mem_req    = (state_q == ST_REQ);
   assign step       = ((state_q == ST_SCAN) && !want_read) || take;
   assign step_idx   = idx_q;
   assign step_clr   = sticky_q || (take && mem_fault);
   assign data_valid = take && !mem_fault;
   assign abort      = abort_q;
   assign done       = (state_q == ST_FIN);

   // R6
   no_read_after_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_q |-> !mem_req);

   // R2
   read_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> act_vec[idx_q]);

   // R5
   abort_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_fault && !first_q) |=> !abort_q);
endmodule

// File: rtl/ffl_store.sv
module ffl_store #(
   parameter int VLEN_P = 256
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [VLEN_P/8-1:0]           ffr_in,
   input  logic                          esize64,
   input  logic                          step,
   input  logic [$clog2(VLEN_P/32)-1:0]  step_idx,
   input  logic                          step_clr,
   input  logic                          data_valid,
   input  logic [31:0]                   rdata,
   output logic [VLEN_P-1:0]             res,
   output logic [VLEN_P/8-1:0]           ffr
);
   import ffl_pkg::*;
   localparam int PLEN   = VLEN_P / 8;
   localparam int NWORD  = VLEN_P / 32;
   localparam int NE64   = VLEN_P / 64;
   localparam int EIDX_W = $clog2(NWORD);

   logic [VLEN_P-1:0] res_q;
   logic [VLEN_P-1:0] res_nxt;
   logic [PLEN-1:0]   ffr_q;
   logic [PLEN-1:0]   ffr_nxt;
   logic              unk_q;
   logic              unk_d;
   logic [NWORD-1:0]  low32;
   logic [NWORD-1:0]  low64;
   logic              cur_low;
   logic [WORD_W-1:0] wdata;

   for (genvar e = 0; e < NWORD; e++) begin : g_low
      assign low32[e] = ffr_q[e*4];
      if (e < NE64) begin : g_wide
         assign low64[e] = ffr_q[e*8];
      end else begin : g_none
         assign low64[e] = 1'b0;
      end
   end

   assign cur_low = (esize64 ? low64[step_idx] : low32[step_idx]) && !step_clr;
   assign unk_d   = unk_q || !cur_low;
   assign wdata   = data_valid ? rdata : '0;

   for (genvar b = 0; b < PLEN; b++) begin : g_byte
      logic in_grp;
      assign in_grp = esize64 ? (step_idx == EIDX_W'(b / 8))
                              : (step_idx == EIDX_W'(b / 4));
      assign ffr_nxt[b] = (step_clr && in_grp) ? 1'b0 : ffr_q[b];
   end

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      logic hit;
      logic [WORD_W-1:0] val;
      assign hit = esize64 ? (step_idx == EIDX_W'(w / 2))
                           : (step_idx == EIDX_W'(w));
      if (w % 2 == 1) begin : g_odd
         assign val = (unk_d || esize64) ? '0 : wdata;
      end else begin : g_even
         assign val = unk_d ? '0 : wdata;
      end
      assign res_nxt[w*WORD_W +: WORD_W] = hit ? val : res_q[w*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         ffr_q <= '0;
         unk_q <= 1'b0;
      end else if (load) begin
         res_q <= '0;
         ffr_q <= ffr_in;
         unk_q <= 1'b0;
      end else if (step) begin
         res_q <= res_nxt;
         ffr_q <= ffr_nxt;
         unk_q <= unk_d;
      end
   end

   assign res = res_q;
   assign ffr = ffr_q;

   // R8
   ffr_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((ffr_q & ~$past(ffr_q)) == '0));
endmodule

// File: rtl/ffload_seq.sv
module ffload_seq #(
   parameter int VLEN_P = 256,
   parameter int AW_P   = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                esize64,
   input  logic [AW_P-1:0]     base_addr,
   input  logic [AW_P-1:0]     index,
   input  logic [VLEN_P/8-1:0] pred,
   input  logic [VLEN_P/8-1:0] ffr_in,
   input  logic [VLEN_P-1:0]   prior_vec,
   output logic                mem_req,
   output logic [AW_P-1:0]     mem_addr,
   input  logic                mem_ack,
   input  logic [31:0]         mem_rdata,
   input  logic                mem_fault,
   output logic                done,
   output logic                sync_fault,
   output logic [VLEN_P-1:0]   result,
   output logic [VLEN_P/8-1:0] ffr_out
);
   localparam int NWORD  = VLEN_P / 32;
   localparam int EIDX_W = $clog2(NWORD);

   if (VLEN_P < 64 || VLEN_P % 64 != 0) begin : g_bad_vlen
      $error("ffload_seq: VLEN_P must be a positive multiple of 64");
   end
   if (AW_P < 8) begin : g_bad_aw
      $error("ffload_seq: AW_P too narrow");
   end

   logic [NWORD-1:0]  act_live;
   logic [NWORD-1:0]  act_q;
   logic              esize_q;
   logic [VLEN_P-1:0] prior_q;
   logic              load;
   logic              step;
   logic [EIDX_W-1:0] step_idx;
   logic              step_clr;
   logic              data_valid;
   logic              abort;
   logic [VLEN_P-1:0] res;

   ffl_pred_map #(.VLEN_P(VLEN_P)) u_pred (
      .pred    (pred),
      .esize64 (esize64),
      .act     (act_live)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         esize_q <= 1'b0;
         prior_q <= '0;
      end else if (load) begin
         act_q   <= act_live;
         esize_q <= esize64;
         prior_q <= prior_vec;
      end
   end

   ffl_ctrl #(.VLEN_P(VLEN_P)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .esize64    (esize_q),
      .act_vec    (act_q),
      .mem_ack    (mem_ack),
      .mem_fault  (mem_fault),
      .load       (load),
      .mem_req    (mem_req),
      .step       (step),
      .step_idx   (step_idx),
      .step_clr   (step_clr),
      .data_valid (data_valid),
      .abort      (abort),
      .done       (done)
   );

   ffl_addr_gen #(.AW_P(AW_P)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .base_addr (base_addr),
      .index     (index),
      .step      (step),
      .addr      (mem_addr)
   );

   ffl_store #(.VLEN_P(VLEN_P)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .ffr_in     (ffr_in),
      .esize64    (esize_q),
      .step       (step),
      .step_idx   (step_idx),
      .step_clr   (step_clr),
      .data_valid (data_valid),
      .rdata      (mem_rdata),
      .res        (res),
      .ffr        (ffr_out)
   );

   assign result     = abort ? prior_q : res;
   assign sync_fault = abort;

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);
endmodule

// File: tb/ffload_seq_tb.sv
module ffload_seq_tb_top;
   localparam int VLEN = 256;
   localparam int PLEN = VLEN / 8;

   typedef struct packed {
      logic        e64;
      logic [63:0] base;
      logic [63:0] idx;
      logic [31:0] pred;
      logic [31:0] ffr;
      logic        fen;
      logic [3:0]  fslot;
      logic [1:0]  lat;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 64'h0000_0000_0000_1000, 64'h3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd0},
      '{1'b0, 64'h0000_0004_0000_0100, 64'h10, 32'h0F0F_00F1, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd1},
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h2, 32'h0101_0101, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd2},
      '{1'b0, 64'h0000_0000_0000_2000, 64'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd0, 2'd1},
      '{1'b0, 64'h0000_0000_0000_3000, 64'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd3, 2'd0},
      '{1'b1, 64'h0000_0000_0000_4000, 64'h5, 32'h0100_0101, 32'hFFFF_FFFF, 1'b1, 4'd1, 2'd1},
      '{1'b0, 64'h0000_0000_0000_5000, 64'h0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd0},
      '{1'b0, 64'h0000_0000_0000_6000, 64'h7, 32'hFFFF_FFFF, 32'hFFFF_0FFF, 1'b0, 4'd0, 2'd0},
      '{1'b0, 64'h0000_0000_0000_7000, 64'h0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1'b1, 4'd1, 2'd2},
      '{1'b0, 64'h0000_0000_0000_8000, 64'h0, 32'hEEEE_EEEE, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd0},
      '{1'b1, 64'h0000_0000_0000_9000, 64'h4, 32'h1010_1011, 32'h00FF_FFFF, 1'b0, 4'd0, 2'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              esize64 = 1'b0;
   logic [63:0]       base_addr = '0;
   logic [63:0]       index = '0;
   logic [PLEN-1:0]   pred = '0;
   logic [PLEN-1:0]   ffr_in = '0;
   logic [VLEN-1:0]   prior_vec = '0;
   logic              mem_req;
   logic [63:0]       mem_addr;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              mem_fault = 1'b0;
   logic              done;
   logic              sync_fault;
   logic [VLEN-1:0]   result;
   logic [PLEN-1:0]   ffr_out;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [63:0]     exp_addr [8];
   int              exp_n;
   int              rd_n;
   logic [63:0]     fault_addr;
   logic            fault_en;
   int              cur_lat;
   logic [VLEN-1:0] exp_res;
   logic [PLEN-1:0] exp_ffr;
   logic            exp_sync;

   always #10 clk = ~clk;

   ffload_seq #(.VLEN_P(VLEN), .AW_P(64)) dut_i (
      .clk, .rst_n, .start, .esize64, .base_addr, .index, .pred, .ffr_in,
      .prior_vec, .mem_req, .mem_addr, .mem_ack, .mem_rdata, .mem_fault,
      .done, .sync_fault, .result, .ffr_out
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] memf(input logic [63:0] a);
      return a[31:0] ^ a[63:32] ^ 32'h1357_9BDF;
   endfunction

   task automatic model(input vec_t v, input logic [VLEN-1:0] prior);
      int nel, grp;
      logic [63:0] a;
      logic first, faulted, unknown, f;
      logic [31:0] d;
      nel = v.e64 ? VLEN / 64 : VLEN / 32;
      grp = v.e64 ? 8 : 4;
      a = v.base + {v.idx[61:0], 2'b00};
      fault_addr = a + 64'(4 * v.fslot);
      fault_en = v.fen;
      first = 1'b1; faulted = 1'b0; unknown = 1'b0;
      exp_res = '0; exp_ffr = v.ffr; exp_sync = 1'b0; exp_n = 0;
      for (int e = 0; e < nel; e++) begin
         d = '0; f = 1'b0;
         if (v.pred[e*grp] && !faulted) begin
            exp_addr[exp_n] = a;
            exp_n++;
            d = memf(a);
            f = v.fen && (a == fault_addr);
            if (first && f) begin
               exp_sync = 1'b1;
               break;
            end
            first = 1'b0;
         end
         if (f) begin
            faulted = 1'b1;
            d = '0;
         end
         if (faulted) begin
            for (int b = 0; b < grp; b++) exp_ffr[e*grp+b] = 1'b0;
         end
         if (!exp_ffr[e*grp]) unknown = 1'b1;
         if (v.e64) exp_res[e*64 +: 64] = unknown ? 64'h0 : {32'h0, d};
         else       exp_res[e*32 +: 32] = unknown ? 32'h0 : d;
         a = a + 64'd4;
      end
      if (exp_sync) begin
         exp_res = prior;
         exp_ffr = v.ffr;
      end
   endtask

   // memory responder: answers after cur_lat waiting cycles
   initial begin
      int wcnt;
      wcnt = 0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         mem_fault = 1'b0;
         if (mem_req === 1'b1) begin
            if (wcnt >= cur_lat) begin
               wcnt = 0;
               mem_ack = 1'b1;
               mem_rdata = memf(mem_addr);
               mem_fault = fault_en && (mem_addr == fault_addr);
               if (rd_n < exp_n)
                  chk(mem_addr == exp_addr[rd_n], "R1 R11 read address",
                      VLEN'(mem_addr), VLEN'(exp_addr[rd_n]));
               else
                  chk(1'b0, "R2 R6 unexpected read", VLEN'(mem_addr), '0);
               rd_n++;
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic run_op(input vec_t v, input int k, input bit poke);
      logic [VLEN-1:0] prior;
      int n;
      prior = {8{32'hA0B0_0000 | 32'(k)}};
      model(v, prior);
      rd_n = 0;
      cur_lat = int'(v.lat);
      @(negedge clk);
      esize64 = v.e64; base_addr = v.base; index = v.idx;
      pred = v.pred; ffr_in = v.ffr; prior_vec = prior;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (done !== 1'b1 && n < 1000) begin
         @(negedge clk);
         n++;
         if (poke && n == 2) begin
            start = 1'b1; base_addr = 64'hDEAD_0000; pred = ~v.pred; ffr_in = '0;
         end else if (poke && n == 3) begin
            start = 1'b0;
         end
      end
      chk(done === 1'b1, "R10 done seen", VLEN'(done), 1);
      chk(result == exp_res, "R2 R3 R4 R7 result", result, exp_res);
      chk(ffr_out == exp_ffr, "R6 R8 ffr_out", VLEN'(ffr_out), VLEN'(exp_ffr));
      chk(sync_fault == exp_sync, "R5 sync_fault", VLEN'(sync_fault), VLEN'(exp_sync));
      chk(rd_n == exp_n, "R2 R9 read count", VLEN'(rd_n), VLEN'(exp_n));
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", VLEN'(done), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL R10 watchdog act=%0d exp=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      vec_t pv;
      exp_n = 0; rd_n = 0; cur_lat = 0; fault_en = 1'b0; fault_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(done == 1'b0, "R10 reset done", VLEN'(done), 0);
      chk(mem_req == 1'b0, "R10 reset mem_req", VLEN'(mem_req), 0);
      chk(sync_fault == 1'b0, "R10 reset sync_fault", VLEN'(sync_fault), 0);
      chk(result == '0, "R10 reset result", result, '0);

      for (int k = 0; k < NV; k++) run_op(TBL[k], k, 1'b0);

      // R10: a second start during a slow run is ignored
      pv = TBL[1];
      pv.lat = 2'd3;
      run_op(pv, 20, 1'b1);
      // R3: only group-low predicate bits count in 64-bit mode
      pv = TBL[2];
      pv.pred = 32'hFEFE_FEFE;
      run_op(pv, 21, 1'b0);
      // R6: sticky fault on the last 32-bit element
      pv = TBL[4];
      pv.fslot = 4'd7;
      run_op(pv, 22, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule